// File: doc/BRIEF.md
# Register-Target Branch Decision Unit

This unit sits beside the execute stage of a small load-store processor. For each branch it decides whether the branch is taken and picks the next program counter. It also produces the link write used by the call form of the branch. Branches only ever jump to an address held in a register. A 3-bit condition code selects one of six tests, each made on the value of a condition register.

The pipeline presents the decoded condition code, the link flag, the condition register value, the target register value and the already-incremented PC, together with a one-cycle strobe. One clock later the unit drives a result-valid flag, the taken decision, the next PC and a link write request. The link write request carries the incremented PC for the destination register. On cycles without a strobe, the decision and link outputs read zero.

Top module: `branch_link_eval`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge clears `res_valid`, `taken`, `link_we`, `next_pc` and `link_data` to zero, even if a strobe is present.
- R2: A strobe sampled at one rising edge produces its results, with `res_valid` high, after that edge. After an edge with no strobe, `res_valid`, `taken` and `link_we` are 0.
- R3: Condition code 0 is never taken, and so are the spare codes 6 and 7.
- R4: Condition code 1 is always taken, whatever the condition value.
- R5: Code 2 is taken when the condition value equals zero. Code 3 is taken when the condition value is nonzero.
- R6: Code 4 is taken when the condition value's most significant bit (bit 31 at the default width) is 0. Code 5 is taken when that bit is 1.
- R7: A taken branch drives `next_pc` with the target register value.
- R8: A branch that is not taken drives `next_pc` with `pc_in`, unchanged.
- R9: With `link_flag` high, `link_we` is 1 and `link_data` equals `pc_in`, whether or not the branch is taken. With `link_flag` low, `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | One-cycle strobe marking a branch to evaluate |
| cond_code | input | 3 | Condition selector, taken from the instruction's three lowest bits |
| link_flag | input | 1 | High for the branch-and-link form |
| cond_val | input | DATA_W | Value of the condition register |
| target_val | input | DATA_W | Value of the target address register |
| pc_in | input | DATA_W | Program counter, already pointing at the next instruction |
| res_valid | output | 1 | Results below belong to the strobe of the previous edge |
| taken | output | 1 | Branch decision |
| next_pc | output | DATA_W | Address of the next instruction to fetch |
| link_we | output | 1 | Write request for the link destination register |
| link_data | output | DATA_W | Value to write into the link register |

## Verification
The bench feeds each code a condition value near its decision edge. These values are zero against one, `0x7FFFFFFF` against `0x80000000`, and all ones. A test that looked at the wrong bit or inverted a comparison would flip `taken` and then select the wrong `next_pc`. The spare codes 6 and 7 are applied with a condition value that would satisfy other tests, so a decoder that aliased them onto real codes would branch. The link form is run on branches that are not taken, which catches a design that gates the link write with the decision. The bench also checks the idle cycles after each strobe and a strobe arriving during reset, so stale or unreset outputs are exposed.

// File: rtl/brl_pkg.sv
// Package: shared widths and the condition code encoding of the branch unit.
// Assumes the condition code is a 3-bit field; codes 6 and 7 are spare.
package brl_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CND_NEVER   = 3'd0,
        CND_ALWAYS  = 3'd1,
        CND_ZERO    = 3'd2,
        CND_NONZERO = 3'd3,
        CND_NONNEG  = 3'd4,
        CND_NEG     = 3'd5
    } cond_e;
endpackage

// File: rtl/brl_cond_check.sv
// Module: brl_cond_check
// Evaluates one of six register tests selected by a 3-bit code.
// Purely combinational. Assumes the sign bit is the value's MSB.
// Spare codes (6, 7) evaluate as false.
module brl_cond_check #(
    parameter int DATA_W = 32
) (
    input  logic [brl_pkg::CODE_W-1:0] code,
    input  logic [DATA_W-1:0]          value,
    output logic                       hit
);
    import brl_pkg::*;

    localparam int SIGN_BIT = DATA_W - 1;

    logic is_zero;
    logic is_neg;

    // Derive the two flags every test is built from.
    always_comb begin
        is_zero = (value == '0);
        is_neg  = value[SIGN_BIT];
    end

    // Select the test named by the code; unknown codes never hit.
    always_comb begin
        case (code)
            CND_ALWAYS:  hit = 1'b1;
            CND_ZERO:    hit = is_zero;
            CND_NONZERO: hit = !is_zero;
            CND_NONNEG:  hit = !is_neg;
            CND_NEG:     hit = is_neg;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brl_next_pc.sv
// Module: brl_next_pc
// Chooses the fetch address: the register target when taken, otherwise
// the incremented PC. Combinational; no offset arithmetic is performed.
module brl_next_pc #(
    parameter int DATA_W = 32
) (
    input  logic              take,
    input  logic [DATA_W-1:0] target,
    input  logic [DATA_W-1:0] seq_pc,
    output logic [DATA_W-1:0] fetch_pc
);
    // Two-way select between jump target and sequential address.
    always_comb begin
        fetch_pc = take ? target : seq_pc;
    end
endmodule

// File: rtl/branch_link_eval.sv
// Module: branch_link_eval (top)
// Decides a register-target branch, picks the next PC and issues the link
// write. Decision logic is combinational; results are registered once, so
// they appear one cycle after the strobe. Synchronous active-low reset.
// Assumes the strobe is a single-cycle pulse per branch.
module branch_link_eval #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       instr_valid,
    input  logic [brl_pkg::CODE_W-1:0] cond_code,
    input  logic                       link_flag,
    input  logic [DATA_W-1:0]          cond_val,
    input  logic [DATA_W-1:0]          target_val,
    input  logic [DATA_W-1:0]          pc_in,
    output logic                       res_valid,
    output logic                       taken,
    output logic [DATA_W-1:0]          next_pc,
    output logic                       link_we,
    output logic [DATA_W-1:0]          link_data
);
    import brl_pkg::*;

    logic              cond_hit;
    logic [DATA_W-1:0] sel_pc;

    brl_cond_check #(.DATA_W(DATA_W)) u_cond (
        .code  (cond_code),
        .value (cond_val),
        .hit   (cond_hit)
    );

    brl_next_pc #(.DATA_W(DATA_W)) u_npc (
        .take     (cond_hit),
        .target   (target_val),
        .seq_pc   (pc_in),
        .fetch_pc (sel_pc)
    );

    // Capture the decision on a strobe; flags drop on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            link_we   <= 1'b0;
            next_pc   <= '0;
            link_data <= '0;
        end else if (instr_valid) begin
            res_valid <= 1'b1;
            taken     <= cond_hit;
            link_we   <= link_flag;
            next_pc   <= sel_pc;
            link_data <= pc_in;
        end else begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            link_we   <= 1'b0;
        end
    end

    // Idle cycles carry no decision or write.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!taken && !link_we));

    // Never and spare codes do not branch.
    assert_never_codes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && ($past(cond_code) == 3'd0 || $past(cond_code) == 3'd6
                       || $past(cond_code) == 3'd7)) |-> !taken);

    // The always code branches.
    assert_always_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cond_code) == 3'd1) |-> taken);

    // Zero test follows the captured condition value.
    assert_zero_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cond_code) == 3'd2) |-> (taken == ($past(cond_val) == '0)));

    // Negative test follows the captured sign bit.
    assert_neg_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cond_code) == 3'd5) |-> (taken == $past(cond_val[DATA_W-1])));

    // Taken branches jump to the register target.
    assert_taken_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && taken) |-> (next_pc == $past(target_val)));

    // Untaken branches keep the incremented PC.
    assert_fall_through_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !taken) |-> (next_pc == $past(pc_in)));

    // Link writes carry the incremented PC of a real strobe.
    assert_link_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (res_valid && link_data == $past(pc_in)));
endmodule

// File: tb/tb_branch_link_eval.sv
module tb_branch_link_eval;
    localparam int W  = 32;
    localparam int NV = 13;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         instr_valid;
    logic [2:0]   cond_code;
    logic         link_flag;
    logic [W-1:0] cond_val, target_val, pc_in;
    logic         res_valid, taken, link_we;
    logic [W-1:0] next_pc, link_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    branch_link_eval #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
        .cond_code(cond_code), .link_flag(link_flag), .cond_val(cond_val),
        .target_val(target_val), .pc_in(pc_in), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc), .link_we(link_we),
        .link_data(link_data)
    );

    // Stimulus table: code, link, condition, target, pc, expected taken.
    localparam logic [2:0]   V_CODE [NV] = '{3'd0, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3,
                                             3'd4, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7, 3'd0};
    localparam logic         V_LINK [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                             1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [W-1:0] V_COND [NV] = '{32'h0, 32'h5, 32'h0, 32'h1,
                                             32'h8000_0000, 32'h0, 32'h7FFF_FFFF,
                                             32'h8000_0000, 32'hFFFF_FFFF, 32'h0,
                                             32'h0, 32'h0, 32'hFFFF_FFFF};
    localparam logic [W-1:0] V_TGT  [NV] = '{32'h100, 32'h200, 32'h300, 32'h300,
                                             32'h400, 32'h400, 32'h500, 32'h500,
                                             32'h600, 32'h600, 32'h700, 32'h800, 32'h900};
    localparam logic [W-1:0] V_PC   [NV] = '{32'h40, 32'h44, 32'h48, 32'h4C, 32'h50,
                                             32'h54, 32'h58, 32'h5C, 32'h60, 32'h64,
                                             32'h68, 32'h6C, 32'h70};
    localparam logic         V_TAKE [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                                             1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

    function automatic string code_req(input logic [2:0] c);
        case (c)
            3'd1:       return "R4";
            3'd2, 3'd3: return "R5";
            3'd4, 3'd5: return "R6";
            default:    return "R3";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_check(input string ctx);
        check("R2", {ctx, " res_valid idle"}, W'(res_valid), '0);
        check("R2", {ctx, " taken idle"},     W'(taken),     '0);
        check("R2", {ctx, " link_we idle"},   W'(link_we),   '0);
    endtask

    initial begin
        rst_n = 1'b0; instr_valid = 1'b1; cond_code = 3'd1; link_flag = 1'b1;
        cond_val = '0; target_val = 32'hDEAD; pc_in = 32'hBEEF;
        repeat (3) @(negedge clk);
        // R1: strobe held during reset leaves everything cleared
        check("R1", "res_valid reset", W'(res_valid), '0);
        check("R1", "taken reset",     W'(taken),     '0);
        check("R1", "link_we reset",   W'(link_we),   '0);
        check("R1", "next_pc reset",   next_pc,       '0);
        check("R1", "link_data reset", link_data,     '0);
        rst_n = 1'b1; instr_valid = 1'b0;
        @(negedge clk);
        idle_check("post-reset");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cond_code = V_CODE[i]; link_flag = V_LINK[i]; cond_val = V_COND[i];
            target_val = V_TGT[i]; pc_in = V_PC[i]; instr_valid = 1'b1;
            @(negedge clk);
            instr_valid = 1'b0;
            check("R2", $sformatf("vec %0d res_valid", i), W'(res_valid), W'(1));
            check(code_req(V_CODE[i]), $sformatf("vec %0d taken", i),
                  W'(taken), W'(V_TAKE[i]));
            if (V_TAKE[i])
                check("R7", $sformatf("vec %0d next_pc", i), next_pc, V_TGT[i]);
            else
                check("R8", $sformatf("vec %0d next_pc", i), next_pc, V_PC[i]);
            check("R9", $sformatf("vec %0d link_we", i), W'(link_we), W'(V_LINK[i]));
            if (V_LINK[i])
                check("R9", $sformatf("vec %0d link_data", i), link_data, V_PC[i]);
            @(negedge clk);
            idle_check($sformatf("after vec %0d", i));
        end

        // Back-to-back strobes: second result follows the first directly
        @(negedge clk);
        cond_code = 3'd3; link_flag = 1'b0; cond_val = 32'h2;
        target_val = 32'hA00; pc_in = 32'h80; instr_valid = 1'b1;
        @(negedge clk);
        check("R5", "b2b first taken", W'(taken), W'(1));
        check("R7", "b2b first next_pc", next_pc, 32'hA00);
        cond_code = 3'd4; link_flag = 1'b1; cond_val = 32'h8000_0001;
        target_val = 32'hB00; pc_in = 32'h84;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R6", "b2b second taken", W'(taken), W'(0));
        check("R8", "b2b second next_pc", next_pc, 32'h84);
        check("R9", "b2b second link_data", link_data, 32'h84);

        // Reset arriving together with a strobe wins
        @(negedge clk);
        rst_n = 1'b0; instr_valid = 1'b1; cond_code = 3'd1; link_flag = 1'b1;
        @(negedge clk);
        check("R1", "reset over strobe taken", W'(taken), '0);
        check("R1", "reset over strobe link_we", W'(link_we), '0);
        check("R1", "reset over strobe next_pc", next_pc, '0);
        rst_n = 1'b1; instr_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule